// File: doc/BRIEF.md
# Memory-Mapped Quad-SPI Flash Read Port

This block lets a processor read a serial NOR flash as if it were plain memory. A bus master raises a read strobe together with a byte address inside the flash window and holds both until the wait line drops. In that cycle the 32-bit word is valid on the data output. Software needs no driver: every read is turned into flash traffic by the block.

When no transfer is open, the block selects the flash and sends the quad fast-read opcode 0xEB. The opcode goes out one bit per clock on data line 0. The address follows four bits per clock, then a mode byte and a run of dummy clocks. Eight quad data clocks then fill one word. After the word is delivered, chip select stays low and a counter holds the address the flash will stream next.

A request that matches the counter resumes clocking straight away, with no new opcode or address. A request that does not match closes the transfer and opens a new one. If no request arrives within a programmable number of cycles, chip select is released. The address width is a parameter and may be 24 or 32 bits.

Top module: `qspi_xip_reader`

## Requirements
- R1: After reset, with no request pending, chip select is high, the serial clock is low, all four output enables are 0 and wait is low. The serial clock never toggles while chip select is high.
- R2: A request with no transfer open pulls chip select low and sends 0xEB most significant bit first on data line 0. During these eight clocks the output enable is 4'b0001.
- R3: After the opcode, the address is sent most significant nibble first, ADDR_W/4 clocks at four bits per clock. Next comes the mode byte (high nibble first, default 0x00) in two clocks. The address and mode clocks drive all four enables to 4'b1111.
- R4: During the 4 dummy clocks and all data clocks, the output enables are 4'b0000.
- R5: One word takes 8 data clocks. The first byte received lands in bits 7:0 and the fourth in bits 31:24. Within each byte the first nibble is the upper one.
- R6: Wait is high while a request is pending and drops in the cycle the word is valid. The serial clock runs at half the system clock. With 24-bit addressing, a read from the closed state completes 57 clock edges after the request is raised.
- R7: A request whose address equals the previous address plus 4 (modulo the address space) completes in 17 edges. It causes no chip select edge and no new opcode.
- R8: A request at any other address while a transfer is open raises chip select in the next cycle. A new opcode and address sequence follows, and the read completes in 59 edges.
- R9: With the transfer open and no request, chip select stays low for idle_limit_i cycles and is high two cycles later. The next read, even at the sequential address, then sends a full opcode and address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | Read strobe, held until wait drops |
| rd_addr_i | input | ADDR_W | Byte address within the flash |
| rd_data_o | output | 32 | Read word, valid when strobe is high and wait low |
| rd_wait_o | output | 1 | Stall to the requesting bus |
| idle_limit_i | input | IDLE_W | Idle cycles before an open transfer is closed |
| qspi_sck_o | output | 1 | Serial clock to the flash |
| qspi_cs_n_o | output | 1 | Active-low chip select |
| qspi_io_o | output | 4 | Data line output values |
| qspi_io_oe_o | output | 4 | Per-line output enable |
| qspi_io_i | input | 4 | Data line input values |

## Verification
If the next-address counter is wrong, a sequential read either returns the wrong word or reopens the flash. A reopen shows as an extra chip select falling edge and a 59-edge latency instead of 17, visible on the very next read. A sequencer phase that is one clock off shifts every nibble, so the flash model sees a bad opcode or address and the first word already mismatches. A broken idle counter shows as chip select still low, or released early, within a few cycles of the programmed limit.

// File: rtl/qxr_pkg.sv
package qxr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA, ST_HOLD, ST_DESEL
   } qxr_state_e;

   localparam logic [7:0] OPC_QUAD_READ = 8'hEB;
   localparam int         WORD_NIBS     = 8;
endpackage

// File: rtl/qxr_addr_track.sv
module qxr_addr_track #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              advance_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              hit_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   logic [ADDR_W-1:0] next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         next_q <= '0;
      else if (load_i)    next_q <= load_addr_i;
      else if (advance_i) next_q <= next_q + STEP;
   end

   assign hit_o = (next_q == req_addr_i);

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_i && !load_i) |=> (next_q == $past(next_q) + STEP)); // R7
endmodule

// File: rtl/qxr_wordpack.sv
module qxr_wordpack
   import qxr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sample_i,
   input  logic [2:0]  idx_i,
   input  logic [3:0]  nib_i,
   output logic [31:0] word_o
);
   for (genvar k = 0; k < WORD_NIBS; k++) begin : g_nib
      localparam int OFS = (k / 2) * 8 + ((k % 2 == 0) ? 4 : 0);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 word_o[OFS +: 4] <= '0;
         else if (sample_i && idx_i == 3'(k))        word_o[OFS +: 4] <= nib_i;
      end
   end
endmodule

// File: rtl/qxr_seq.sv
module qxr_seq
   import qxr_pkg::*;
#(
   parameter int         ADDR_W     = 24,
   parameter int         IDLE_W     = 16,
   parameter int         DUMMY_CLKS = 4,
   parameter logic [7:0] MODE_BYTE  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              hit_i,
   input  logic [IDLE_W-1:0] idle_limit_i,
   output logic              sck_o,
   output logic              cs_n_o,
   output logic [3:0]        io_o,
   output logic [3:0]        io_oe_o,
   output logic              load_o,
   output logic              advance_o,
   output logic              sample_o,
   output logic [2:0]        nib_idx_o,
   output logic              ack_o
);
   localparam int ADDR_CLKS = ADDR_W / 4;
   localparam int CNT_W     = 4;

   if (DUMMY_CLKS < 1 || DUMMY_CLKS > 16) begin : g_bad_dummy
      $error("DUMMY_CLKS must lie in 1..16");
   end

   qxr_state_e        state;
   logic              ph;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last;
   logic [ADDR_W-1:0] addr_sr;
   logic [IDLE_W-1:0] idle_cnt;
   logic              pend;
   logic              active;

   always_comb begin
      unique case (state)
         ST_CMD:   last = CNT_W'(7);
         ST_ADDR:  last = CNT_W'(ADDR_CLKS - 1);
         ST_MODE:  last = CNT_W'(1);
         ST_DUMMY: last = CNT_W'(DUMMY_CLKS - 1);
         default:  last = CNT_W'(WORD_NIBS - 1);
      endcase
   end

   assign active = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_MODE) ||
                   (state == ST_DUMMY) || (state == ST_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ph       <= 1'b0;
         cnt      <= '0;
         addr_sr  <= '0;
         idle_cnt <= '0;
         pend     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_i) begin
               state   <= ST_CMD;
               ph      <= 1'b0;
               cnt     <= '0;
               addr_sr <= addr_i;
            end
            ST_CMD, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA: begin
               ph <= ~ph;
               if (ph) begin
                  if (state == ST_ADDR) addr_sr <= {addr_sr[ADDR_W-5:0], 4'b0000};
                  if (cnt == last) begin
                     cnt <= '0;
                     unique case (state)
                        ST_CMD:   state <= ST_ADDR;
                        ST_ADDR:  state <= ST_MODE;
                        ST_MODE:  state <= ST_DUMMY;
                        ST_DUMMY: state <= ST_DATA;
                        default: begin
                           state    <= ST_HOLD;
                           pend     <= 1'b1;
                           idle_cnt <= '0;
                        end
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_HOLD: begin
               if (pend) begin
                  if (req_i) pend <= 1'b0;
               end else if (req_i) begin
                  idle_cnt <= '0;
                  ph       <= 1'b0;
                  cnt      <= '0;
                  state    <= hit_i ? ST_DATA : ST_DESEL;
               end else if (idle_cnt >= idle_limit_i) begin
                  state <= ST_DESEL;
               end else begin
                  idle_cnt <= idle_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      io_o    = 4'b0000;
      io_oe_o = 4'b0000;
      unique case (state)
         ST_CMD: begin
            io_o    = {3'b000, OPC_QUAD_READ[3'(7 - cnt[2:0])]};
            io_oe_o = 4'b0001;
         end
         ST_ADDR: begin
            io_o    = addr_sr[ADDR_W-1 -: 4];
            io_oe_o = 4'b1111;
         end
         ST_MODE: begin
            io_o    = cnt[0] ? MODE_BYTE[3:0] : MODE_BYTE[7:4];
            io_oe_o = 4'b1111;
         end
         default: ;
      endcase
   end

   assign sck_o     = active && ph;
   assign cs_n_o    = (state == ST_IDLE) || (state == ST_DESEL);
   assign load_o    = (state == ST_IDLE) && req_i;
   assign sample_o  = (state == ST_DATA) && ph;
   assign nib_idx_o = cnt[2:0];
   assign advance_o = sample_o && (cnt == CNT_W'(WORD_NIBS - 1));
   assign ack_o     = (state == ST_HOLD) && pend && req_i;

   AST_HIT_STREAMS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !pend && req_i && hit_i) |=> (!cs_n_o && state == ST_DATA)); // R7
   AST_MISS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !pend && req_i && !hit_i) |=> cs_n_o); // R8
   AST_IDLE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !pend && !req_i && idle_cnt >= idle_limit_i) |=> cs_n_o); // R9
   AST_LINES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_o && (state == ST_DUMMY || state == ST_DATA)) |-> (io_oe_o == 4'b0000)); // R4
   AST_WORD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      advance_o |=> (state == ST_HOLD && pend && !cs_n_o)); // R6
endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader #(
   parameter int         ADDR_W     = 24,
   parameter int         IDLE_W     = 16,
   parameter int         DUMMY_CLKS = 4,
   parameter logic [7:0] MODE_BYTE  = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [31:0]       rd_data_o,
   output logic              rd_wait_o,
   input  logic [IDLE_W-1:0] idle_limit_i,
   output logic              qspi_sck_o,
   output logic              qspi_cs_n_o,
   output logic [3:0]        qspi_io_o,
   output logic [3:0]        qspi_io_oe_o,
   input  logic [3:0]        qspi_io_i
);
   if (ADDR_W != 24 && ADDR_W != 32) begin : g_bad_addr
      $error("ADDR_W must be 24 or 32");
   end
   if (IDLE_W < 1) begin : g_bad_idle
      $error("IDLE_W must be positive");
   end

   logic       hit, load, advance, sample, ack;
   logic [2:0] nib_idx;

   qxr_seq #(
      .ADDR_W(ADDR_W), .IDLE_W(IDLE_W), .DUMMY_CLKS(DUMMY_CLKS), .MODE_BYTE(MODE_BYTE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_i(rd_req_i), .addr_i(rd_addr_i), .hit_i(hit),
      .idle_limit_i(idle_limit_i), .sck_o(qspi_sck_o), .cs_n_o(qspi_cs_n_o),
      .io_o(qspi_io_o), .io_oe_o(qspi_io_oe_o), .load_o(load), .advance_o(advance),
      .sample_o(sample), .nib_idx_o(nib_idx), .ack_o(ack)
   );

   qxr_addr_track #(.ADDR_W(ADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .load_i(load), .load_addr_i(rd_addr_i),
      .advance_i(advance), .req_addr_i(rd_addr_i), .hit_o(hit)
   );

   qxr_wordpack u_pack (
      .clk(clk), .rst_n(rst_n), .sample_i(sample), .idx_i(nib_idx),
      .nib_i(qspi_io_i), .word_o(rd_data_o)
   );

   assign rd_wait_o = rd_req_i && !ack;

   AST_SCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      qspi_cs_n_o |-> !qspi_sck_o); // R1
   AST_NO_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req_i |-> !rd_wait_o); // R6
endmodule

// File: tb/qspi_xip_reader_bench.sv
module qspi_xip_reader_bench;
   localparam int AW = 24;
   localparam int AC = AW / 4;
   localparam int N0 = 8 + AC + 2 + 4;
   localparam int IDLE_L = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   rdata;
   logic          wait_s;
   logic [15:0]   idle_limit = 16'(IDLE_L);
   logic          sck, cs_n;
   logic [3:0]    io_o, io_oe;
   logic [3:0]    io_i = 4'h0;

   int n_chk = 0, n_bad = 0, edges = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   qspi_xip_reader u_qspi_xip_reader (
      .clk(clk), .rst_n(rst_n), .rd_req_i(req), .rd_addr_i(addr), .rd_data_o(rdata),
      .rd_wait_o(wait_s), .idle_limit_i(idle_limit), .qspi_sck_o(sck), .qspi_cs_n_o(cs_n),
      .qspi_io_o(io_o), .qspi_io_oe_o(io_oe), .qspi_io_i(io_i)
   );

   // ---- flash model ----
   int          rises = 0, cs_falls = 0;
   int          oe_err_cmd = 0, oe_err_out = 0, oe_err_in = 0;
   logic [7:0]  f_cmd = '0, f_mode = '0;
   logic [AW-1:0] f_addr = '0;

   function automatic logic [7:0] fbyte(input logic [AW-1:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] expw(input logic [AW-1:0] a);
      return {fbyte(a + 24'd3), fbyte(a + 24'd2), fbyte(a + 24'd1), fbyte(a)};
   endfunction

   always @(negedge cs_n) begin
      cs_falls++;
      rises = 0;
   end

   always @(posedge sck) if (!cs_n) begin
      if (rises < 8) begin
         f_cmd = {f_cmd[6:0], io_o[0]};
         if (io_oe != 4'b0001) oe_err_cmd++;
      end else if (rises < 8 + AC) begin
         f_addr = {f_addr[AW-5:0], io_o};
         if (io_oe != 4'b1111) oe_err_out++;
      end else if (rises < 8 + AC + 2) begin
         f_mode = {f_mode[3:0], io_o};
         if (io_oe != 4'b1111) oe_err_out++;
      end else if (io_oe != 4'b0000) oe_err_in++;
      rises++;
   end

   always @(negedge sck) if (!cs_n && rises >= N0) begin
      automatic int k = rises - N0;
      automatic logic [7:0] b = fbyte(f_addr + AW'(k / 2));
      io_i <= #1 ((k % 2) == 0) ? b[7:4] : b[3:0];
   end

   // ---- checking ----
   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output int cyc);
      req  = 1'b1;
      addr = a;
      cyc  = 0;
      do begin
         @(posedge clk); cyc++;
         @(negedge clk);
      end while (wait_s && cyc < 500);
      d = rdata;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cs_n", 32'(cs_n), 32'd1);
      chk("R1 sck", 32'(sck), 32'd0);
      chk("R1 oe", 32'(io_oe), 32'd0);
      chk("R1 wait", 32'(wait_s), 32'd0);
   endtask

   task automatic t_first(input logic [AW-1:0] a);
      logic [31:0] d; int c; int f0 = cs_falls;
      do_read(a, d, c);
      chk("R6 first latency", 32'(c), 32'd57);
      chk("R5 first word", d, expw(a));
      chk("R2 opcode", 32'(f_cmd), 32'hEB);
      chk("R2 cmd enables", 32'(oe_err_cmd), 32'd0);
      chk("R3 address", 32'(f_addr), 32'(a));
      chk("R3 mode byte", 32'(f_mode), 32'h00);
      chk("R3 out enables", 32'(oe_err_out), 32'd0);
      chk("R4 input enables", 32'(oe_err_in), 32'd0);
      chk("R2 one select", 32'(cs_falls - f0), 32'd1);
   endtask

   task automatic t_seq(input logic [AW-1:0] a);
      logic [31:0] d; int c; int f0 = cs_falls;
      do_read(a, d, c);
      chk("R7 seq latency", 32'(c), 32'd17);
      chk("R7 seq word", d, expw(a));
      chk("R7 no reselect", 32'(cs_falls - f0), 32'd0);
   endtask

   task automatic t_jump(input logic [AW-1:0] a);
      logic [31:0] d; int c; int f0 = cs_falls;
      do_read(a, d, c);
      chk("R8 jump latency", 32'(c), 32'd59);
      chk("R8 jump word", d, expw(a));
      chk("R8 reselect", 32'(cs_falls - f0), 32'd1);
      chk("R8 new address", 32'(f_addr), 32'(a));
      chk("R4 input enables", 32'(oe_err_in), 32'd0);
   endtask

   task automatic t_idle(input logic [AW-1:0] nxt);
      logic [31:0] d; int c; int f0;
      repeat (IDLE_L) @(posedge clk);
      @(negedge clk);
      chk("R9 still open at limit", 32'(cs_n), 32'd0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R9 released", 32'(cs_n), 32'd1);
      f0 = cs_falls;
      do_read(nxt, d, c);
      chk("R9 reopen latency", 32'(c), 32'd57);
      chk("R9 reopen select", 32'(cs_falls - f0), 32'd1);
      chk("R9 reopen word", d, expw(nxt));
   endtask

   initial begin
      while (!done) begin
         @(posedge clk);
         edges++;
         if (edges > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", edges);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first(24'h000100);
      t_seq(24'h000104);
      t_seq(24'h000108);
      t_jump(24'h002000);
      t_seq(24'h002004);
      t_jump(24'hFFFFF8);
      t_seq(24'hFFFFFC);
      t_seq(24'h000000);
      t_idle(24'h000004);
      t_jump(24'h7A5430);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule